// File: doc/BRIEF.md
# Banked Translation Fault Reporting Unit

This block records the outcome of a failed address-translation request. It sits beside a translation engine. When a walk fails, the engine presents one failure event. That event carries a 13-bit fault status code, the faulting address, an external-abort flag and the security state of the requester. A routing control bit decides whether external aborts go to the secure side.

The unit keeps two banks, one secure and one non-secure. Each bank holds a 32-bit translation result word, a fault status register and a fault address register. An ordinary failure writes only the result word of the issuing bank and makes no noise. A failure caused by an external abort during the table fetch leaves both result words alone and pulses an abort towards the core. It also writes the fault status and fault address of a bank. That bank is either the issuing bank, or the secure bank with a monitor trap when routing is on.

Software reaches the registers through a small access port. That port has a privilege input and a current-security input. An unprivileged access is refused and flagged as an undefined-instruction case.

Top module: `xlat_fault_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bank register clears to zero and `abort_pulse`, `mon_trap` and `undef_pulse` go low.
- R2: A failure with `fail_ext`=0 sets the issuing bank's result word, by the next edge, to: bit 0 = 1, bits [6:1] = {code[12], code[10], code[3:0]} (high to low), and bits [31:7] = 0. The issuing bank is secure when `fail_secure`=1.
- R3: A failure with `fail_ext`=0 leaves all fault status and fault address registers unchanged, leaves the other bank's result word unchanged, and produces no abort or trap. This holds whatever the value of `ext_route`.
- R4: A failure with `fail_ext`=1 leaves both result words unchanged and makes `abort_pulse` high for exactly the cycle after the event.
- R5: A failure with `fail_ext`=1 and `ext_route`=1 writes the code and address into the secure bank's fault status and fault address registers, whatever the value of `fail_secure`. It also pulses `mon_trap` in the same cycle as `abort_pulse`.
- R6: A failure with `fail_ext`=1 and `ext_route`=0 writes the fault status and fault address of the bank chosen by `fail_secure`, and `mon_trap` stays low.
- R7: A privileged read (`acc_vld`=1, `acc_wr`=0, `acc_priv`=1) loads `rd_data` at the next edge. The value comes from the bank chosen by `cur_secure`, with `acc_sel` 0 = result word, 1 = fault status, 2 = fault address and 3 = reads zero. Narrower registers are zero-extended.
- R8: A privileged write updates only the selected register of the bank chosen by `cur_secure`. The result word keeps wdata[6:0] and the fault status keeps wdata[12:0]; all higher bits read back as zero. A write with `acc_sel`=3 changes nothing.
- R9: Any access with `acc_priv`=0 changes no register and leaves `rd_data` unchanged, and `undef_pulse` is high for the next cycle only.
- R10: When a failure event and a privileged write target the same register in the same cycle, the failure's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fail_vld | input | 1 | One-cycle failure event |
| fail_code | input | 13 | Fault status code of the failure |
| fail_addr | input | 32 | Faulting address |
| fail_ext | input | 1 | Failure was an external abort on the table fetch |
| fail_secure | input | 1 | Security state of the requester (1 = secure) |
| ext_route | input | 1 | Route external aborts to the secure bank with a monitor trap |
| acc_vld | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | Access is privileged |
| cur_secure | input | 1 | Current security state, selects the bank |
| acc_sel | input | 2 | Register select (0 result, 1 status, 2 address) |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| abort_pulse | output | 1 | Abort to the core |
| mon_trap | output | 1 | Monitor-mode trap |
| undef_pulse | output | 1 | Undefined-instruction indication |

## Verification
On every cycle, the assertions check these properties:
- Each abort, trap and undefined pulse has the cause that permits it.
- An external abort never disturbs either result word.
- An ordinary failure never disturbs the fault status registers.
- An unprivileged access never changes a register.
- A result word written by a failure always carries its abort flag.

Only the bench's scenarios can show the following:
- The packed bit order.
- The bank chosen for each combination of security state and routing.
- Zero-extension of reserved bits.
- Write isolation between the banks.
- The priority of a failure over a colliding write.

// File: rtl/xfr_pkg.sv
// Package for the translation fault reporting unit.
// Holds the register select encoding, the bank indices and the
// function that packs a fault status code into the result word.
// Assumes a fault status code at least 13 bits wide.
package xfr_pkg;

    typedef enum logic [1:0] {
        SEL_RESULT = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ADDR   = 2'd2,
        SEL_NONE   = 2'd3
    } xfr_sel_e;

    localparam int NUM_BANKS = 2;
    localparam int BANK_NS   = 0;
    localparam int BANK_S    = 1;
    localparam int RES_W     = 7;

    // Packs status bits 12, 10, 3..0 above an abort flag in bit 0.
    function automatic logic [RES_W-1:0] pack_result(input logic [12:0] fs);
        return {fs[12], fs[10], fs[3:0], 1'b1};
    endfunction

endpackage

// File: rtl/xfr_route_dec.sv
// Failure routing decoder.
// Decides, for one failure event, which bank's result word or fault
// registers are written, and whether an abort and a monitor trap are raised.
// Assumes fail_vld is a single-cycle strobe. Purely combinational.
module xfr_route_dec
    import xfr_pkg::*;
(
    input  logic                 fail_vld,
    input  logic                 fail_ext,
    input  logic                 fail_secure,
    input  logic                 ext_route,
    output logic [NUM_BANKS-1:0] upd_res,
    output logic [NUM_BANKS-1:0] upd_flt,
    output logic                 raise_abort,
    output logic                 raise_trap
);

    // Chooses the destination of a failure from its kind and the routing bit.
    always_comb begin
        upd_res     = '0;
        upd_flt     = '0;
        raise_abort = 1'b0;
        raise_trap  = 1'b0;
        if (fail_vld) begin
            if (fail_ext) begin
                raise_abort = 1'b1;
                if (ext_route) begin
                    upd_flt[BANK_S] = 1'b1;
                    raise_trap      = 1'b1;
                end else begin
                    upd_flt[fail_secure] = 1'b1;
                end
            end else begin
                upd_res[fail_secure] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xfr_access.sv
// Register access qualifier.
// Splits an access into a bank write enable, a read enable and an
// undefined indication, based on privilege and the current security state.
// Assumes acc_vld is a single-cycle strobe. Purely combinational.
module xfr_access
    import xfr_pkg::*;
(
    input  logic                 acc_vld,
    input  logic                 acc_wr,
    input  logic                 acc_priv,
    input  logic                 cur_secure,
    output logic [NUM_BANKS-1:0] sw_we,
    output logic                 rd_en,
    output logic                 undef_set
);

    // Rejects unprivileged accesses and steers writes to the current bank.
    always_comb begin
        sw_we     = '0;
        undef_set = acc_vld && !acc_priv;
        rd_en     = acc_vld && acc_priv && !acc_wr;
        if (acc_vld && acc_priv && acc_wr) begin
            sw_we[cur_secure] = 1'b1;
        end
    end

endmodule

// File: rtl/xfr_bank.sv
// One security bank of the fault reporting unit.
// Holds the packed result word, the fault status and the fault address.
// A hardware update has priority over a software write to the same register.
// Assumes FS_W <= DATA_W and ADDR_W <= DATA_W.
module xfr_bank
    import xfr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int FS_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_set,
    input  logic [RES_W-1:0]  res_val,
    input  logic              flt_set,
    input  logic [FS_W-1:0]   fs_val,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              sw_we,
    input  xfr_sel_e          sw_sel,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [RES_W-1:0]  res_q,
    output logic [FS_W-1:0]   fs_q,
    output logic [ADDR_W-1:0] addr_q
);

    // Result word: a failure first, otherwise a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (res_set) begin
            res_q <= res_val;
        end else if (sw_we && sw_sel == SEL_RESULT) begin
            res_q <= sw_wdata[RES_W-1:0];
        end
    end

    // Fault status and address: an external abort first, otherwise software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q   <= '0;
            addr_q <= '0;
        end else if (flt_set) begin
            fs_q   <= fs_val;
            addr_q <= addr_val;
        end else if (sw_we) begin
            if (sw_sel == SEL_STATUS) fs_q   <= sw_wdata[FS_W-1:0];
            if (sw_sel == SEL_ADDR)   addr_q <= sw_wdata[ADDR_W-1:0];
        end
    end

    a_r2_abort_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        res_set |=> res_q[0]);

    a_r10_hw_addr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flt_set |=> addr_q == $past(addr_val));

endmodule

// File: rtl/xlat_fault_bank.sv
// Banked translation fault reporting unit (top).
// Routes failure events into the secure or non-secure bank, raises the
// abort, trap and undefined pulses one cycle later, and serves privileged
// register reads with one cycle of latency.
// Assumes single-cycle strobes on fail_vld and acc_vld.
module xlat_fault_bank
    import xfr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int FS_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_vld,
    input  logic [FS_W-1:0]   fail_code,
    input  logic [ADDR_W-1:0] fail_addr,
    input  logic              fail_ext,
    input  logic              fail_secure,
    input  logic              ext_route,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic              acc_priv,
    input  logic              cur_secure,
    input  logic [1:0]        acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              abort_pulse,
    output logic              mon_trap,
    output logic              undef_pulse
);

    localparam int CODE_W = 13;

    logic [NUM_BANKS-1:0] upd_res;
    logic [NUM_BANKS-1:0] upd_flt;
    logic [NUM_BANKS-1:0] sw_we;
    logic                 raise_abort;
    logic                 raise_trap;
    logic                 rd_en;
    logic                 undef_set;
    logic [RES_W-1:0]     res_val;
    logic [DATA_W-1:0]    rd_mux;
    xfr_sel_e             sel;

    logic [RES_W-1:0]  res_q  [NUM_BANKS];
    logic [FS_W-1:0]   fs_q   [NUM_BANKS];
    logic [ADDR_W-1:0] addr_q [NUM_BANKS];

    assign sel     = xfr_sel_e'(acc_sel);
    assign res_val = pack_result(fail_code[CODE_W-1:0]);

    xfr_route_dec u_dec (
        .fail_vld    (fail_vld),
        .fail_ext    (fail_ext),
        .fail_secure (fail_secure),
        .ext_route   (ext_route),
        .upd_res     (upd_res),
        .upd_flt     (upd_flt),
        .raise_abort (raise_abort),
        .raise_trap  (raise_trap)
    );

    xfr_access u_acc (
        .acc_vld    (acc_vld),
        .acc_wr     (acc_wr),
        .acc_priv   (acc_priv),
        .cur_secure (cur_secure),
        .sw_we      (sw_we),
        .rd_en      (rd_en),
        .undef_set  (undef_set)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        xfr_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .FS_W   (FS_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .res_set  (upd_res[b]),
            .res_val  (res_val),
            .flt_set  (upd_flt[b]),
            .fs_val   (fail_code),
            .addr_val (fail_addr),
            .sw_we    (sw_we[b]),
            .sw_sel   (sel),
            .sw_wdata (acc_wdata),
            .res_q    (res_q[b]),
            .fs_q     (fs_q[b]),
            .addr_q   (addr_q[b])
        );
    end

    // Selects the current bank's register and zero-extends it.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_RESULT: rd_mux = DATA_W'(res_q[cur_secure]);
            SEL_STATUS: rd_mux = DATA_W'(fs_q[cur_secure]);
            SEL_ADDR:   rd_mux = DATA_W'(addr_q[cur_secure]);
            default:    rd_mux = '0;
        endcase
    end

    // Registers the read data; it holds when there is no privileged read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    // Turns the decoded events into single-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_pulse <= 1'b0;
            mon_trap    <= 1'b0;
            undef_pulse <= 1'b0;
        end else begin
            abort_pulse <= raise_abort;
            mon_trap    <= raise_trap;
            undef_pulse <= undef_set;
        end
    end

    a_r4_abort_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> $past(fail_vld && fail_ext));

    a_r5_trap_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
        mon_trap |-> abort_pulse);

    a_r9_undef_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        undef_pulse |-> $past(acc_vld && !acc_priv));

    a_r4_result_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_vld && fail_ext && !(acc_vld && acc_wr))
        |=> ($stable(res_q[0]) && $stable(res_q[1])));

    a_r3_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_vld && !fail_ext && !(acc_vld && acc_wr))
        |=> ($stable(fs_q[0]) && $stable(fs_q[1])
             && $stable(addr_q[0]) && $stable(addr_q[1])));

    a_r9_user_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_priv && !fail_vld)
        |=> ($stable(res_q[0]) && $stable(res_q[1]) && $stable(fs_q[0])
             && $stable(fs_q[1]) && $stable(addr_q[0]) && $stable(addr_q[1])
             && $stable(rd_data)));

    a_r8_one_bank_written: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_we));

endmodule

// File: tb/xlat_fault_bank_bench.sv
`timescale 1ns/1ps
module xlat_fault_bank_bench;

    localparam int  NVEC    = 8;
    localparam time TIMEOUT = 200_000ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fail_vld, fail_ext, fail_secure, ext_route;
    logic [12:0] fail_code;
    logic [31:0] fail_addr;
    logic        acc_vld, acc_wr, acc_priv, cur_secure;
    logic [1:0]  acc_sel;
    logic [31:0] acc_wdata;
    logic [31:0] rd_data;
    logic        abort_pulse, mon_trap, undef_pulse;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Reference model of the banks: index 0 non-secure, 1 secure.
    logic [31:0] m_res [2];
    logic [31:0] m_fs  [2];
    logic [31:0] m_adr [2];

    // Vector: {sec, ext, route, code[12:0], addr[31:0], exp_abort, exp_trap}
    localparam logic [49:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 13'h1405, 32'h0000_1000, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b0, 13'h0007, 32'h0000_2000, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 13'h0008, 32'h1000_0040, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b0, 13'h0406, 32'hA5A5_0000, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 13'h1C08, 32'hDEAD_BEEC, 1'b1, 1'b1},
        {1'b1, 1'b1, 1'b1, 13'h0016, 32'h0000_0004, 1'b1, 1'b1},
        {1'b0, 1'b0, 1'b1, 13'h1FFF, 32'h3333_3333, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b0, 13'h0BF0, 32'h4444_4444, 1'b0, 1'b0}
    };

    xlat_fault_bank u_xlat_fault_bank (
        .clk(clk), .rst_n(rst_n),
        .fail_vld(fail_vld), .fail_code(fail_code), .fail_addr(fail_addr),
        .fail_ext(fail_ext), .fail_secure(fail_secure), .ext_route(ext_route),
        .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_priv(acc_priv),
        .cur_secure(cur_secure), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .abort_pulse(abort_pulse), .mon_trap(mon_trap),
        .undef_pulse(undef_pulse)
    );

    always #10ns clk = ~clk;

    function automatic logic [31:0] pack(input logic [12:0] c);
        return {25'd0, c[12], c[10], c[3], c[2], c[1], c[0], 1'b1};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            m_res[b] = '0; m_fs[b] = '0; m_adr[b] = '0;
        end
    endtask

    task automatic idle();
        fail_vld = 0; fail_ext = 0; fail_secure = 0; ext_route = 0;
        fail_code = '0; fail_addr = '0;
        acc_vld = 0; acc_wr = 0; acc_priv = 0; cur_secure = 0;
        acc_sel = 2'd0; acc_wdata = '0;
    endtask

    // One failure event; returns the pulses seen in the following cycle.
    task automatic do_fail(input logic sec, ext, route, input logic [12:0] code,
                           input logic [31:0] addr, output logic ab, output logic tr);
        @(negedge clk);
        fail_vld = 1; fail_secure = sec; fail_ext = ext; ext_route = route;
        fail_code = code; fail_addr = addr;
        @(negedge clk);
        idle();
        ab = abort_pulse; tr = mon_trap;
    endtask

    // One register access; returns rd_data and undef the cycle after.
    task automatic do_acc(input logic wr, priv, sec, input logic [1:0] sel,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic und);
        @(negedge clk);
        acc_vld = 1; acc_wr = wr; acc_priv = priv; cur_secure = sec;
        acc_sel = sel; acc_wdata = wd;
        @(negedge clk);
        idle();
        rd = rd_data; und = undef_pulse;
    endtask

    task automatic check_all(input string req);
        logic [31:0] rd;
        logic        und;
        for (int b = 0; b < 2; b++) begin
            do_acc(0, 1, b[0], 2'd0, '0, rd, und);
            check(req, $sformatf("bank%0d result", b), rd, m_res[b]);
            do_acc(0, 1, b[0], 2'd1, '0, rd, und);
            check(req, $sformatf("bank%0d status", b), rd, m_fs[b]);
            do_acc(0, 1, b[0], 2'd2, '0, rd, und);
            check(req, $sformatf("bank%0d address", b), rd, m_adr[b]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(TIMEOUT);
        tests++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic        und, ab, tr;
        logic [49:0] v;
        idle();
        model_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1: pulses low and banks clear after reset
        check("R1", "abort after reset", {31'd0, abort_pulse}, 32'd0);
        check("R1", "trap after reset", {31'd0, mon_trap}, 32'd0);
        check("R1", "undef after reset", {31'd0, undef_pulse}, 32'd0);
        rst_n = 1;
        check_all("R1");

        // R2..R6: table of failure events
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            do_fail(v[49], v[48], v[47], v[46:34], v[33:2], ab, tr);
            check(v[48] ? "R4" : "R3", $sformatf("vec%0d abort", i),
                  {31'd0, ab}, {31'd0, v[1]});
            check(v[47] ? "R5" : "R6", $sformatf("vec%0d trap", i),
                  {31'd0, tr}, {31'd0, v[0]});
            if (!v[48]) begin
                m_res[v[49]] = pack(v[46:34]);
            end else if (v[47]) begin
                m_fs[1] = {19'd0, v[46:34]}; m_adr[1] = v[33:2];
            end else begin
                m_fs[v[49]] = {19'd0, v[46:34]}; m_adr[v[49]] = v[33:2];
            end
            check_all(v[48] ? (v[47] ? "R5" : "R6") : "R2");
        end

        // R7: select 3 reads zero
        do_acc(0, 1, 1, 2'd3, '0, rd, und);
        check("R7", "select 3 read", rd, 32'd0);

        // R8: writes hit only the current bank, reserved bits zero
        do_acc(1, 1, 0, 2'd0, 32'hFFFF_FFFF, rd, und);
        m_res[0] = 32'h0000_007F;
        do_acc(1, 1, 0, 2'd1, 32'hFFFF_FFFF, rd, und);
        m_fs[0] = 32'h0000_1FFF;
        do_acc(1, 1, 1, 2'd2, 32'h8765_4321, rd, und);
        m_adr[1] = 32'h8765_4321;
        do_acc(1, 1, 1, 2'd3, 32'hFFFF_FFFF, rd, und);
        check_all("R8");

        // R9: unprivileged accesses
        do_acc(0, 1, 1, 2'd2, '0, rd, und);
        do_acc(0, 0, 0, 2'd1, '0, rd, und);
        check("R9", "user read undef", {31'd0, und}, 32'd1);
        check("R9", "user read keeps rd_data", rd, 32'h8765_4321);
        @(negedge clk);
        check("R9", "undef single cycle", {31'd0, undef_pulse}, 32'd0);
        do_acc(1, 0, 0, 2'd0, 32'h0000_0000, rd, und);
        check("R9", "user write undef", {31'd0, und}, 32'd1);
        do_acc(1, 0, 1, 2'd2, 32'h0000_0000, rd, und);
        check_all("R9");

        // R10: failure and write to the same result word in one cycle
        @(negedge clk);
        fail_vld = 1; fail_secure = 0; fail_ext = 0; fail_code = 13'h0403;
        acc_vld = 1; acc_wr = 1; acc_priv = 1; cur_secure = 0;
        acc_sel = 2'd0; acc_wdata = 32'h0000_0000;
        @(negedge clk);
        idle();
        m_res[0] = pack(13'h0403);
        // R10: external abort and status write to the same bank collide
        @(negedge clk);
        fail_vld = 1; fail_secure = 1; fail_ext = 1; ext_route = 1;
        fail_code = 13'h0111; fail_addr = 32'hCAFE_0010;
        acc_vld = 1; acc_wr = 1; acc_priv = 1; cur_secure = 1;
        acc_sel = 2'd1; acc_wdata = 32'h0000_0AAA;
        @(negedge clk);
        idle();
        m_fs[1] = 32'h0000_0111; m_adr[1] = 32'hCAFE_0010;
        check_all("R10");

        // R4: abort pulse lasts one cycle
        do_fail(0, 1, 0, 13'h0002, 32'h0000_0100, ab, tr);
        m_fs[0] = 32'h0000_0002; m_adr[0] = 32'h0000_0100;
        @(negedge clk);
        check("R4", "abort single cycle", {31'd0, abort_pulse}, 32'd0);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        check_all("R1");

        finish_run();
    end

endmodule